// File: doc/BRIEF.md
# Quarter-Rate Shift Real-to-Complex Resampler

This block takes a stream of real 16-bit converter samples and turns it into complex baseband I/Q pairs. The real stream is rotated down by a quarter of its own sample rate. The rotation needs no multipliers, because the rotating phasor only ever takes the values 1, -j, -1 and +j. Each of the I and Q branches then passes through a fixed low-pass filter, and the output is decimated to half the clock rate.

The input arrives either on every clock (`rate_sel` = 0) or on three clocks out of four (`rate_sel` = 1). In full-rate mode the block keeps every second filtered point. In three-quarter mode it produces two outputs for each three inputs. It does this by alternating between two polyphase kernels: an odd-length kernel centred on a sample, and an even-length kernel centred halfway between two samples. In both modes the output pairs average one per two clocks.

`rate_sel` is expected to stay stable between resets.

Top module: `fs4_resampler`

## Requirements
- R1: A synchronous active-high `rst` clears the mixer phase, the filter history and the decimation counter. In the cycle after the reset edge, `bb_vld` is 0 and both `bb_i` and `bb_q` are 0.
- R2: Accepted samples are numbered n = 0, 1, 2, … from reset. The mixer phase is n mod 4, and the mixed pair (I, Q) for phase 0, 1, 2 and 3 is (x, 0), (0, -x), (-x, 0) and (0, +x). Values are kept at 17 bits so that -(-32768) is exact.
- R3: The whole-sample kernel weights the five newest mixed values by 1, 4, 6, 4, 1 (newest first). It divides by 16, rounding halves toward +infinity, and clamps the result to the signed 16-bit range.
- R4: With `rate_sel` = 0, an output is produced for each accepted sample with odd n, using the whole-sample kernel. Two outputs never appear in consecutive cycles.
- R5: With `rate_sel` = 1, each accepted sample is handled by n mod 3. For n mod 3 = 1 the output uses the half-sample kernel: weights 1, 5, 10, 10, 5, 1 over the six newest values, divided by 32 with the same rounding and clamp. For n mod 3 = 2 the output uses the whole-sample kernel. For n mod 3 = 0 there is no output.
- R6: A sample accepted at clock edge k that produces an output makes `bb_vld` high, with its data, during the cycle after edge k+1. In every other cycle `bb_vld` is low.
- R7: While `smp_vld` is low, `smp_data` is ignored. The mixer phase and the filter history hold their values.
- R8: With `rate_sel` = 1 and valid present on 3 of every 4 clocks, exactly 2 outputs are produced per 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | 0: input at clock rate, 1: input at three quarters of clock rate |
| smp_vld | input | 1 | Input sample strobe |
| smp_data | input | 16 | Real input sample, two's complement |
| bb_vld | output | 1 | Output pair strobe |
| bb_i | output | 16 | In-phase output |
| bb_q | output | 16 | Quadrature output |

## Verification
A sample captured at one edge lands in the filter history and sets the decimation decision at that edge. The rounded result is registered at the following edge, so each output is due two edges after its input. The bench drives at falling edges and carries its own expectation through a two-stage pipeline. In every cycle it compares `bb_vld` and the data against the stage that has matured, so both missing and early outputs are seen. Impulse tests log the output sequence and compare it with values worked out by hand for each mode, including the rounding of half steps. Counts over long windows confirm the decimation ratios.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic {
    RATE_FULL = 1'b0,
    RATE_3Q   = 1'b1
  } rate_e;

  // Binomial coefficient, used to build the low-pass kernels.
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

endpackage

// File: rtl/rs_mixer.sv
module rs_mixer #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic [DW-1:0]        in_data,
  output logic signed [DW:0]   mix_i,
  output logic signed [DW:0]   mix_q
);

  logic [1:0]         phase;
  logic signed [DW:0] ext;
  logic signed [DW:0] neg;

  // Phase of the quarter-rate rotation, stepped only by accepted samples.
  always_ff @(posedge clk) begin
    if (rst) phase <= 2'd0;
    else if (in_vld) phase <= phase + 2'd1;
  end

  always_comb begin
    ext = {in_data[DW-1], in_data};
    neg = -ext;
    mix_i = '0;
    mix_q = '0;
    case (phase)
      2'd0: mix_i = ext;
      2'd1: mix_q = neg;
      2'd2: mix_i = neg;
      default: mix_q = ext;
    endcase
  end

  assert_phase_adv_R2: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> phase == $past(phase) + 2'd1);

  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(phase));

endmodule

// File: rtl/rs_rate_ctrl.sv
module rs_rate_ctrl
  import rs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_vld,
  input  rate_e mode,
  output logic  fire,
  output logic  half
);

  logic [1:0] cnt;
  logic [1:0] last;
  logic       emit;
  logic       emit_half;

  // cnt holds n mod 2 (full rate) or n mod 3 (three-quarter rate).
  always_comb begin
    last      = (mode == RATE_3Q) ? 2'd2 : 2'd1;
    emit      = in_vld && (cnt != 2'd0);
    emit_half = in_vld && (mode == RATE_3Q) && (cnt == 2'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= 2'd0;
      fire <= 1'b0;
      half <= 1'b0;
    end else begin
      fire <= emit;
      half <= emit_half;
      if (in_vld) cnt <= (cnt == last) ? 2'd0 : cnt + 2'd1;
    end
  end

  assert_full_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == RATE_FULL && fire) |=> !fire);

  assert_half_mode_R5: assert property (@(posedge clk) disable iff (rst)
    half |-> mode == RATE_3Q);

endmodule

// File: rtl/rs_fir_branch.sv
module rs_fir_branch
  import rs_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ORDER = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  logic signed [DW:0]    din,
  output logic signed [DW-1:0]  y_full,
  output logic signed [DW-1:0]  y_half
);

  localparam int NT = ORDER + 2;          // history length for the longer kernel
  localparam int AW = DW + ORDER + 3;     // accumulator width
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [AW-1:0] MINV = ~MAXV;

  logic signed [DW:0]   win [NT];
  logic signed [AW-1:0] acc_f;
  logic signed [AW-1:0] acc_h;

  function automatic logic signed [DW-1:0] round_sat(
    input logic signed [AW-1:0] a,
    input int                   sh
  );
    logic signed [AW-1:0] bias;
    logic signed [AW-1:0] r;
    bias = '0;
    bias[sh-1] = 1'b1;
    r = (a + bias) >>> sh;
    if (r > MAXV) return MAXV[DW-1:0];
    if (r < MINV) return MINV[DW-1:0];
    return r[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NT; i++) win[i] <= '0;
    end else if (shift_en) begin
      win[0] <= din;
      for (int i = 1; i < NT; i++) win[i] <= win[i-1];
    end
  end

  // Whole-sample phase: binomial row ORDER; half-sample phase: row ORDER+1.
  always_comb begin
    acc_f = '0;
    for (int k = 0; k <= ORDER; k++)
      acc_f = acc_f + AW'(int'(win[k]) * binom(ORDER, k));
    acc_h = '0;
    for (int k = 0; k <= ORDER + 1; k++)
      acc_h = acc_h + AW'(int'(win[k]) * binom(ORDER + 1, k));
    y_full = round_sat(acc_f, ORDER);
    y_half = round_sat(acc_h, ORDER + 1);
  end

  assert_win_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(win[0]));

endmodule

// File: rtl/fs4_resampler.sv
module fs4_resampler
  import rs_pkg::*;
#(
  parameter int DW    = 16,
  parameter int ORDER = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rate_sel,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  output logic          bb_vld,
  output logic [DW-1:0] bb_i,
  output logic [DW-1:0] bb_q
);

  rate_e              mode;
  logic signed [DW:0] mix_i;
  logic signed [DW:0] mix_q;
  logic               fire;
  logic               half;
  logic signed [DW-1:0] yi_full, yi_half, yq_full, yq_half;

  assign mode = rate_e'(rate_sel);

  rs_mixer #(.DW(DW)) u_mix (
    .clk(clk), .rst(rst), .in_vld(smp_vld), .in_data(smp_data),
    .mix_i(mix_i), .mix_q(mix_q)
  );

  rs_rate_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_vld(smp_vld), .mode(mode),
    .fire(fire), .half(half)
  );

  rs_fir_branch #(.DW(DW), .ORDER(ORDER)) u_fir_i (
    .clk(clk), .rst(rst), .shift_en(smp_vld), .din(mix_i),
    .y_full(yi_full), .y_half(yi_half)
  );

  rs_fir_branch #(.DW(DW), .ORDER(ORDER)) u_fir_q (
    .clk(clk), .rst(rst), .shift_en(smp_vld), .din(mix_q),
    .y_full(yq_full), .y_half(yq_half)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bb_vld <= 1'b0;
      bb_i   <= '0;
      bb_q   <= '0;
    end else begin
      bb_vld <= fire;
      if (fire) begin
        bb_i <= half ? yi_half : yi_full;
        bb_q <= half ? yq_half : yq_full;
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bb_vld && bb_i == '0 && bb_q == '0));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    bb_vld |-> $past(smp_vld, 2));

endmodule

// File: tb/tb_fs4_resampler.sv
module tb_fs4_resampler;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rate_sel = 1'b0;
  logic        smp_vld = 1'b0;
  logic [15:0] smp_data = '0;
  logic        bb_vld;
  logic [15:0] bb_i;
  logic [15:0] bb_q;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string req = "R1";

  int bwi [6];
  int bwq [6];
  int bph, bcn;
  int p_whole [7];
  int p_half [7];
  int e1_v, e1_i, e1_q, e2_v, e2_i, e2_q;
  int lg_i [512];
  int lg_q [512];
  int nlog, ocount;

  fs4_resampler dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .smp_vld(smp_vld),
    .smp_data(smp_data), .bb_vld(bb_vld), .bb_i(bb_i), .bb_q(bb_q)
  );

  always #5 clk = ~clk;

  function automatic int rsat(input int a, input int sh);
    int r;
    r = (a + (1 << (sh - 1))) >>> sh;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 6; k++) begin bwi[k] = 0; bwq[k] = 0; end
    bph = 0; bcn = 0;
  endtask

  task automatic model_step(input logic v, input logic [15:0] d);
    int x, mi, mq, ai, aq;
    bit em, hf;
    e1_v = 0; e1_i = 0; e1_q = 0;
    if (!v) return;
    x = int'($signed(d));
    mi = 0; mq = 0;
    if (bph == 0) mi = x;
    else if (bph == 1) mq = -x;
    else if (bph == 2) mi = -x;
    else mq = x;
    for (int k = 5; k > 0; k--) begin bwi[k] = bwi[k-1]; bwq[k] = bwq[k-1]; end
    bwi[0] = mi; bwq[0] = mq;
    if (rate_sel == 1'b0) begin em = (bcn == 1); hf = 0; end
    else begin em = (bcn != 0); hf = (bcn == 1); end
    if (em) begin
      ai = 0; aq = 0;
      if (hf) begin
        for (int k = 0; k < 6; k++) begin ai += p_half[k] * bwi[k]; aq += p_half[k] * bwq[k]; end
        e1_i = rsat(ai, 5); e1_q = rsat(aq, 5);
      end else begin
        for (int k = 0; k < 5; k++) begin ai += p_whole[k] * bwi[k]; aq += p_whole[k] * bwq[k]; end
        e1_i = rsat(ai, 4); e1_q = rsat(aq, 4);
      end
      e1_v = 1;
    end
    bph = (bph + 1) % 4;
    bcn = (bcn + 1) % (rate_sel ? 3 : 2);
  endtask

  task automatic tick(input logic v, input logic [15:0] d);
    @(negedge clk);
    total++;
    if (int'(bb_vld) != e2_v) begin
      bad++;
      $display("FAIL %s: bb_vld actual=%0d expected=%0d at %0t", req, bb_vld, e2_v, $time);
    end else if (e2_v != 0) begin
      total++;
      if (int'($signed(bb_i)) != e2_i || int'($signed(bb_q)) != e2_q) begin
        bad++;
        $display("FAIL %s: I/Q actual=%0d/%0d expected=%0d/%0d at %0t", req,
                 $signed(bb_i), $signed(bb_q), e2_i, e2_q, $time);
      end
    end
    if (bb_vld) begin
      ocount++;
      if (nlog < 512) begin lg_i[nlog] = int'($signed(bb_i)); lg_q[nlog] = int'($signed(bb_q)); nlog++; end
    end
    e2_v = e1_v; e2_i = e1_i; e2_q = e1_q;
    smp_vld = v; smp_data = d;
    if (rst) begin
      model_clear();
      e1_v = 0; e2_v = 0;
    end else model_step(v, d);
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1; rate_sel = mode;
    repeat (3) tick(1'b0, 16'h0);
    rst = 1'b0;
    nlog = 0; ocount = 0;
  endtask

  task automatic check_eq(input string tag, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R6: watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    int row [7];
    row = '{1, 0, 0, 0, 0, 0, 0};
    for (int r = 1; r <= 5; r++) begin
      for (int k = r; k > 0; k--) row[k] = row[k] + row[k-1];
      if (r == 4) p_whole = row;
      if (r == 5) p_half = row;
    end
    e1_v = 0; e2_v = 0; e1_i = 0; e1_q = 0; e2_i = 0; e2_q = 0;
    model_clear();
    void'($urandom(32'd4242));

    // R1: outputs cleared by reset
    req = "R1";
    do_reset(1'b0);
    tick(1'b0, 16'h0);
    check_eq("R1 bb_vld after reset", int'(bb_vld), 0);
    check_eq("R1 bb_i after reset", int'(bb_i), 0);
    check_eq("R1 bb_q after reset", int'(bb_q), 0);

    // R3/R2: impulse at phase 0, full rate
    req = "R3";
    do_reset(1'b0);
    tick(1'b1, 16'd1600);
    for (int i = 0; i < 7; i++) tick(1'b1, 16'd0);
    repeat (3) tick(1'b0, 16'd0);
    check_eq("R3 impulse I[0]", lg_i[0], 400);
    check_eq("R3 impulse I[1]", lg_i[1], 400);
    check_eq("R3 impulse I[2]", lg_i[2], 0);
    check_eq("R2 impulse Q[0]", lg_q[0], 0);
    check_eq("R4 output count", ocount, 4);

    // R2: impulse at phase 1 lands on Q with negated sign
    req = "R2";
    do_reset(1'b0);
    tick(1'b1, 16'd0);
    tick(1'b1, 16'd1600);
    for (int i = 0; i < 6; i++) tick(1'b1, 16'd0);
    repeat (3) tick(1'b0, 16'd0);
    check_eq("R2 Q[0]", lg_q[0], -100);
    check_eq("R2 Q[1]", lg_q[1], -600);
    check_eq("R2 Q[2]", lg_q[2], -100);
    check_eq("R2 I[1]", lg_i[1], 0);

    // R3: rounding of half steps
    req = "R3";
    do_reset(1'b0);
    tick(1'b1, 16'd2);
    tick(1'b1, 16'd0);
    repeat (3) tick(1'b0, 16'd0);
    check_eq("R3 round +0.5", lg_i[0], 1);
    do_reset(1'b0);
    tick(1'b1, 16'hFFFE);
    tick(1'b1, 16'd0);
    repeat (3) tick(1'b0, 16'd0);
    check_eq("R3 round -0.5", lg_i[0], 0);

    // R7: data on idle cycles is ignored
    req = "R7";
    do_reset(1'b0);
    tick(1'b1, 16'd1600);
    tick(1'b0, 16'h7FFF);
    tick(1'b0, 16'h8000);
    for (int i = 0; i < 5; i++) begin tick(1'b1, 16'd0); tick(1'b0, 16'h5A5A); end
    repeat (3) tick(1'b0, 16'h1234);
    check_eq("R7 I[0] unaffected", lg_i[0], 400);
    check_eq("R7 I[1] unaffected", lg_i[1], 400);

    // R5: impulse in three-quarter mode
    req = "R5";
    do_reset(1'b1);
    tick(1'b1, 16'd3200);
    for (int i = 0; i < 6; i++) tick(1'b1, 16'd0);
    repeat (3) tick(1'b0, 16'd0);
    check_eq("R5 half phase I[0]", lg_i[0], 500);
    check_eq("R5 whole phase I[1]", lg_i[1], 1200);
    check_eq("R5 half phase I[2]", lg_i[2], 500);
    check_eq("R5 output count", ocount, 4);

    // R4/R6: random data with random gaps, full rate
    req = "R4";
    do_reset(1'b0);
    for (int i = 0; i < 1500; i++) tick(($urandom % 4) != 0, 16'($urandom));
    repeat (3) tick(1'b0, 16'd0);
    // R4: exact ratio over a counted run
    do_reset(1'b0);
    for (int i = 0; i < 100; i++) begin
      tick(1'b1, 16'($urandom));
      if ((i % 3) == 0) tick(1'b0, 16'($urandom));
    end
    repeat (3) tick(1'b0, 16'd0);
    check_eq("R4 count for 100 inputs", ocount, 50);

    // R8/R5/R6: three-of-four cadence with random data, extremes mixed in
    req = "R8";
    do_reset(1'b1);
    for (int g = 0; g < 100; g++) begin
      for (int j = 0; j < 3; j++) begin
        logic [15:0] dv;
        dv = 16'($urandom);
        if (($urandom % 8) == 0) dv = 16'h8000;
        if (($urandom % 8) == 0) dv = 16'h7FFF;
        tick(1'b1, dv);
      end
      tick(1'b0, 16'($urandom));
    end
    repeat (3) tick(1'b0, 16'd0);
    check_eq("R8 outputs per 400 clocks", ocount, 200);

    // R5: random gaps in three-quarter mode
    req = "R5";
    do_reset(1'b1);
    for (int i = 0; i < 1500; i++) tick(($urandom % 3) != 0, 16'($urandom));
    repeat (3) tick(1'b0, 16'd0);

    done = 1;
    finish_run();
  end

endmodule